// File: doc/BRIEF.md
# PC-Indexed Stride Prefetcher

This block observes demand misses from a cache and proposes prefetch addresses. Each miss carries the PC of the load that caused it, the missing address, a requester identifier, an instruction-fetch flag and a security bit. A set-associative table, indexed by the load PC, learns a per-load address stride. Once a load has repeated the same stride often enough, the block issues addresses one, two, and up to several strides beyond the current access.

Instruction-fetch misses do not use the stride table. Each one produces prefetches for the cache blocks that follow the missing block in sequence. All candidates go into a small in-order queue and leave on a valid/ready output toward the downstream prefetch queue. A separate input clears any single table entry.

Top module: `stride_pf`

## Requirements
- R1: After reset the table holds no valid entry and `pf_valid_o` is 0.
- R2: A data request selects set `req_pc_i[SET_W+1:2]`. It hits a way only when that way is valid and matches on the upper PC bits, the requester ID and the security bit. On a miss the lowest-numbered invalid way is filled, or else the victim chosen by the replacement policy. The new entry has stride 0 and confidence 0, and the access produces no prefetch.
- R3: On a hit the observed stride is `addr - last_addr`. A match raises a 2-bit saturating confidence. When the stride matches and the updated confidence is at least CONF_THRESH (2), DEGREE (2) prefetches `addr + k*stride`, k = 1..DEGREE, are queued in order of k. They are visible on the output after the clock edge that accepts the request.
- R4: A mismatch at confidence 0 adopts the new stride at once. Otherwise a first mismatch keeps the stride and confidence and sets a pending-mispredict flag. A second consecutive mismatch adopts the new stride and zeroes confidence. A match clears the flag.
- R5: A zero stride gives no prefetch. Any target below 0 or at or above 2^ADDR_W is dropped, for positive and negative strides alike.
- R6: An instruction-fetch request neither reads nor changes the table. It queues the NBLK (2) block addresses following the block of `req_addr_i`, with blocks of BLK_BYTES (64) bytes, in ascending order. Targets past the top of the address space are dropped.
- R7: Entries are private to a requester ID. Accesses from one ID never alter another ID's training.
- R8: Entries are private to the security state. A secure access never hits or alters a non-secure entry, and the reverse also holds.
- R9: `inv_valid_i` clears the valid bit of way `inv_way_i` in set `inv_set_i`. If a request updates that same entry in the same cycle, the clear takes effect.
- R10: With REPL = REPL_PLRU, each way of a set has a recently-used bit. A touch sets the bit, and when all bits become set only the touched way's bit stays set. The victim is the lowest way whose bit is clear. With REPL = REPL_RANDOM, the victim comes from a free-running LFSR.
- R11: Prefetches leave in queue order. While `pf_valid_o` is 1 and `pf_ready_i` is 0, the output holds its address. Candidates that do not fit in the FIFO_DEPTH (8) queue are dropped, keeping the lowest k that fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Miss request present this cycle |
| req_pc_i | input | PC_W | PC of the missing access |
| req_addr_i | input | ADDR_W | Missing byte address |
| req_rid_i | input | RID_W | Requester identifier |
| req_ifetch_i | input | 1 | Request is an instruction fetch |
| req_secure_i | input | 1 | Request is secure |
| inv_valid_i | input | 1 | Clear one table entry |
| inv_set_i | input | SET_W | Set of entry to clear |
| inv_way_i | input | WAY_W | Way of entry to clear |
| pf_valid_o | output | 1 | Prefetch address available |
| pf_addr_o | output | ADDR_W | Prefetch address |
| pf_ready_i | input | 1 | Downstream takes the prefetch |

## Verification
A request is accepted on one rising edge. The table update and every queued prefetch appear after that same edge, so the head of the queue is visible one cycle after the request was driven. The bench drives requests on falling edges and holds `pf_ready_i` low while it issues them. After the accepting edge it drains the queue one entry per cycle, comparing each head at the following falling edge. It then checks that the queue is empty, which also proves the absence of prefetches where none are due.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  typedef enum logic {REPL_PLRU = 1'b0, REPL_RANDOM = 1'b1} repl_e;
  localparam int CONF_W = 2;
endpackage

// File: rtl/stride_pf_victim.sv
module stride_pf_victim #(
  parameter int WAYS = 2,
  parameter stride_pf_pkg::repl_e REPL = stride_pf_pkg::REPL_PLRU,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  mru_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [15:0]      lfsr_q;
  logic [WAY_W-1:0] policy_way;
  logic             unused_mix;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lfsr_q <= 16'hACE1;
    else         lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};

  assign unused_mix = ^{mru_i, lfsr_q};

  generate
    if (REPL == stride_pf_pkg::REPL_PLRU) begin : g_plru
      always_comb begin
        policy_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
          if (!mru_i[w]) policy_way = WAY_W'(w);
      end
    end else begin : g_rand
      always_comb begin
        policy_way = lfsr_q[WAY_W-1:0];
        if (int'(policy_way) >= WAYS) policy_way = '0;
      end
    end
  endgenerate

  // invalid ways are always filled first
  always_comb begin
    victim_o = policy_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) victim_o = WAY_W'(w);
  end
endmodule

// File: rtl/stride_pf_gen.sv
module stride_pf_gen #(
  parameter int ADDR_W = 32,
  parameter int MAXN   = 2,
  localparam int CNT_W = $clog2(MAXN + 1),
  localparam int EXT_W = ADDR_W + 2 + CNT_W
) (
  input  logic [ADDR_W-1:0]           base_i,
  input  logic [ADDR_W-1:0]           step_i,
  input  logic [CNT_W-1:0]            cnt_i,
  output logic [MAXN-1:0][ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]            n_o
);
  logic [MAXN-1:0] ok;

  generate
    for (genvar k = 0; k < MAXN; k++) begin : g_tgt
      logic signed [EXT_W-1:0] sum;
      assign sum = $signed({{(EXT_W-ADDR_W){1'b0}}, base_i})
                 + $signed({{(EXT_W-ADDR_W){step_i[ADDR_W-1]}}, step_i}) * $signed(EXT_W'(k + 1));
      assign ok[k]     = (CNT_W'(k) < cnt_i) && (sum[EXT_W-1:ADDR_W] == '0);
      assign addr_o[k] = sum[ADDR_W-1:0];
    end
  endgenerate

  // targets are monotonic, so the in-range ones form a prefix
  always_comb begin
    logic run;
    run = 1'b1;
    n_o = '0;
    for (int k = 0; k < MAXN; k++) begin
      if (run && ok[k]) n_o = n_o + CNT_W'(1);
      else              run = 1'b0;
    end
  end
endmodule

// File: rtl/stride_pf_fifo.sv
module stride_pf_fifo #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int MAXN   = 2,
  localparam int CNT_W = $clog2(MAXN + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = PTR_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CNT_W-1:0]            push_n_i,
  input  logic [MAXN-1:0][ADDR_W-1:0] push_addr_i,
  output logic                        valid_o,
  output logic [ADDR_W-1:0]           addr_o,
  input  logic                        ready_i
);
  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [OCC_W-1:0]  occ_q, free_c, nwr_c;
  logic              pop;

  assign valid_o = (occ_q != '0);
  assign addr_o  = mem_q[rd_q];
  assign pop     = valid_o & ready_i;
  assign free_c  = OCC_W'(DEPTH) - occ_q;
  assign nwr_c   = (OCC_W'(push_n_i) < free_c) ? OCC_W'(push_n_i) : free_c;

  always_ff @(posedge clk_i)
    for (int k = 0; k < MAXN; k++)
      if (OCC_W'(k) < nwr_c) mem_q[wr_q + PTR_W'(k)] <= push_addr_i[k];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; occ_q <= '0;
    end else begin
      wr_q  <= wr_q + PTR_W'(nwr_c);
      rd_q  <= rd_q + PTR_W'(pop);
      occ_q <= occ_q + nwr_c - OCC_W'(pop);
    end

  assert_fifo_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OCC_W'(DEPTH));
  assert_fifo_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o));
endmodule

// File: rtl/stride_pf.sv
module stride_pf
  import stride_pf_pkg::*;
#(
  parameter int    ADDR_W      = 32,
  parameter int    PC_W        = 32,
  parameter int    RID_W       = 2,
  parameter int    SETS        = 4,
  parameter int    WAYS        = 2,
  parameter int    BLK_BYTES   = 64,
  parameter int    NBLK        = 2,
  parameter int    DEGREE      = 2,
  parameter int    CONF_THRESH = 2,
  parameter int    FIFO_DEPTH  = 8,
  parameter repl_e REPL        = REPL_PLRU,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = PC_W - SET_W - 2,
  localparam int BLK_W = $clog2(BLK_BYTES),
  localparam int MAXN  = (DEGREE > NBLK) ? DEGREE : NBLK,
  localparam int CNT_W = $clog2(MAXN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PC_W-1:0]   req_pc_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [RID_W-1:0]  req_rid_i,
  input  logic              req_ifetch_i,
  input  logic              req_secure_i,
  input  logic              inv_valid_i,
  input  logic [SET_W-1:0]  inv_set_i,
  input  logic [WAY_W-1:0]  inv_way_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  input  logic              pf_ready_i
);
  typedef struct packed {
    logic              valid;
    logic [TAG_W-1:0]  tag;
    logic [RID_W-1:0]  rid;
    logic              sec;
    logic [ADDR_W-1:0] last;
    logic [ADDR_W-1:0] stride;
    logic [CONF_W-1:0] conf;
    logic              miss;
  } ent_t;
  localparam int ENT_W = $bits(ent_t);

  ent_t             tab_q [SETS][WAYS];
  logic [WAYS-1:0]  mru_q [SETS];

  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              look, hit, match, stride_fire;
  logic [WAYS-1:0]   hit_vec, set_valid, mru_nxt;
  logic [WAY_W-1:0]  hit_way, victim, wr_way;
  ent_t              cur, upd, wr_ent;
  logic [ADDR_W-1:0] obs_stride, gen_base, gen_step;
  logic [CNT_W-1:0]  gen_cnt, push_n;
  logic [MAXN-1:0][ADDR_W-1:0] push_addr;
  logic              unused_pc;

  assign set_idx   = req_pc_i[SET_W+1:2];
  assign req_tag   = req_pc_i[PC_W-1:SET_W+2];
  assign unused_pc = ^req_pc_i[1:0];
  assign look      = req_valid_i & ~req_ifetch_i;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign set_valid[w] = tab_q[set_idx][w].valid;
      assign hit_vec[w]   = tab_q[set_idx][w].valid && tab_q[set_idx][w].tag == req_tag &&
                            tab_q[set_idx][w].rid == req_rid_i &&
                            tab_q[set_idx][w].sec == req_secure_i;
    end
  endgenerate

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign hit = |hit_vec;
  assign cur = tab_q[set_idx][hit_way];
  assign obs_stride = req_addr_i - cur.last;
  assign match = (obs_stride == cur.stride);

  always_comb begin
    upd = cur;
    upd.last = req_addr_i;
    if (match) begin
      if (cur.conf != '1) upd.conf = cur.conf + CONF_W'(1);
      upd.miss = 1'b0;
    end else if (cur.conf == '0) begin
      upd.stride = obs_stride;
      upd.miss   = 1'b0;
    end else if (!cur.miss) begin
      upd.miss = 1'b1;
    end else begin
      upd.stride = obs_stride;
      upd.conf   = '0;
      upd.miss   = 1'b0;
    end
  end

  stride_pf_victim #(.WAYS(WAYS), .REPL(REPL)) u_victim (
    .clk_i, .rst_ni, .valid_i(set_valid), .mru_i(mru_q[set_idx]), .victim_o(victim));

  always_comb begin
    wr_way = hit ? hit_way : victim;
    if (hit) wr_ent = upd;
    else begin
      wr_ent        = '0;
      wr_ent.valid  = 1'b1;
      wr_ent.tag    = req_tag;
      wr_ent.rid    = req_rid_i;
      wr_ent.sec    = req_secure_i;
      wr_ent.last   = req_addr_i;
    end
    mru_nxt = mru_q[set_idx] | (WAYS'(1) << wr_way);
    if (&mru_nxt) mru_nxt = WAYS'(1) << wr_way;
  end

  assign stride_fire = look && hit && match && cur.stride != '0 &&
                       upd.conf >= CONF_W'(CONF_THRESH);

  always_comb begin
    gen_base = req_addr_i;
    gen_step = cur.stride;
    gen_cnt  = '0;
    if (req_valid_i && req_ifetch_i) begin
      gen_base = {req_addr_i[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
      gen_step = ADDR_W'(BLK_BYTES);
      gen_cnt  = CNT_W'(NBLK);
    end else if (stride_fire) begin
      gen_cnt  = CNT_W'(DEGREE);
    end
  end

  stride_pf_gen #(.ADDR_W(ADDR_W), .MAXN(MAXN)) u_gen (
    .base_i(gen_base), .step_i(gen_step), .cnt_i(gen_cnt), .addr_o(push_addr), .n_o(push_n));

  stride_pf_fifo #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .MAXN(MAXN)) u_fifo (
    .clk_i, .rst_ni, .push_n_i(push_n), .push_addr_i(push_addr),
    .valid_o(pf_valid_o), .addr_o(pf_addr_o), .ready_i(pf_ready_i));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        mru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tab_q[s][w] <= '0;
      end
    end else begin
      if (look) begin
        tab_q[set_idx][wr_way] <= wr_ent;
        mru_q[set_idx]         <= mru_nxt;
      end
      if (inv_valid_i) tab_q[inv_set_i][inv_way_i].valid <= 1'b0; // clear wins
    end

  logic [SETS*WAYS*ENT_W-1:0] tab_flat;
  generate
    for (genvar s = 0; s < SETS; s++) begin : g_fs
      for (genvar w = 0; w < WAYS; w++) begin : g_fw
        assign tab_flat[(s*WAYS+w)*ENT_W +: ENT_W] = tab_q[s][w];
      end
    end
  endgenerate

  assert_hit_unique_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot0(hit_vec));
  assert_ifetch_no_train_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ifetch_i && !inv_valid_i |=> tab_flat == $past(tab_flat));
  assert_conf_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    look && hit && cur.conf != '0 && wr_ent.conf == '0 |-> cur.miss);
endmodule

// File: tb/stride_pf_tb.sv
module stride_pf_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_pc_i = '0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_rid_i = '0;
  logic        req_ifetch_i = 1'b0;
  logic        req_secure_i = 1'b0;
  logic        inv_valid_i = 1'b0;
  logic [1:0]  inv_set_i = '0;
  logic        inv_way_i = 1'b0;
  logic        pf_valid_o;
  logic [31:0] pf_addr_o;
  logic        pf_ready_i = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_a [16];
  int exp_n = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stride_pf u_dut (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_pc_i, .req_addr_i, .req_rid_i,
    .req_ifetch_i, .req_secure_i, .inv_valid_i, .inv_set_i, .inv_way_i,
    .pf_valid_o, .pf_addr_o, .pf_ready_i);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; req_valid_i = 1'b0; inv_valid_i = 1'b0; pf_ready_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(pf_valid_o == 1'b0, "R1 reset valid", 32'(pf_valid_o), 32'h0);
  endtask

  task automatic req(input logic [31:0] pc, input logic [31:0] addr, input logic [1:0] rid,
                     input bit ifetch, input bit sec);
    req_valid_i = 1'b1; req_pc_i = pc; req_addr_i = addr;
    req_rid_i = rid; req_ifetch_i = ifetch; req_secure_i = sec;
    @(negedge clk);
    req_valid_i = 1'b0; inv_valid_i = 1'b0;
  endtask

  task automatic dreq(input logic [31:0] pc, input logic [31:0] addr);
    req(pc, addr, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic inv(input logic [1:0] s, input logic w);
    inv_valid_i = 1'b1; inv_set_i = s; inv_way_i = w;
    @(negedge clk);
    inv_valid_i = 1'b0;
  endtask

  task automatic expect_n(input string r, input int n, input logic [31:0] a0, input logic [31:0] a1);
    exp_n = n; exp_a[0] = a0; exp_a[1] = a1;
    for (int i = 0; i < exp_n; i++) begin
      check(pf_valid_o == 1'b1, r, 32'(pf_valid_o), 32'h1);
      check(pf_addr_o == exp_a[i], r, pf_addr_o, exp_a[i]);
      pf_ready_i = 1'b1;
      @(negedge clk);
    end
    pf_ready_i = 1'b0;
    check(pf_valid_o == 1'b0, {r, " empty"}, 32'(pf_valid_o), 32'h0);
  endtask

  task automatic t_reset_alloc();
    do_reset();
    dreq(32'h100, 32'h1000); expect_n("R2 miss alloc", 0, 0, 0);
    dreq(32'h100, 32'h1040); expect_n("R2 stride adopt", 0, 0, 0);
  endtask

  task automatic t_train();
    do_reset();
    dreq(32'h100, 32'h1000); dreq(32'h100, 32'h1040);
    dreq(32'h100, 32'h1080); expect_n("R3 conf1", 0, 0, 0);
    dreq(32'h100, 32'h10C0); expect_n("R3 fire", 2, 32'h1100, 32'h1140);
    dreq(32'h100, 32'h1100); expect_n("R3 saturate", 2, 32'h1140, 32'h1180);
  endtask

  task automatic t_mispredict();
    do_reset();
    dreq(32'h100, 32'h1000); dreq(32'h100, 32'h1040); dreq(32'h100, 32'h1080);
    dreq(32'h100, 32'h10C0); expect_n("R4 trained", 2, 32'h1100, 32'h1140);
    dreq(32'h100, 32'h8000); expect_n("R4 first miss", 0, 0, 0);
    dreq(32'h100, 32'h8040); expect_n("R4 kept conf", 2, 32'h8080, 32'h80C0);
    dreq(32'h100, 32'h9000); dreq(32'h100, 32'h9100);
    expect_n("R4 two misses", 0, 0, 0);
    dreq(32'h100, 32'h9200); expect_n("R4 conf reset", 0, 0, 0);
    dreq(32'h100, 32'h9300); expect_n("R4 retrained", 2, 32'h9400, 32'h9500);
  endtask

  task automatic t_suppress();
    do_reset();
    for (int i = 0; i < 4; i++) dreq(32'h100, 32'h5000);
    expect_n("R5 zero stride", 0, 0, 0);
    do_reset();
    dreq(32'h100, 32'h2000); dreq(32'h100, 32'h1FC0); dreq(32'h100, 32'h1F80);
    dreq(32'h100, 32'h1F40); expect_n("R5 negative", 2, 32'h1F00, 32'h1EC0);
    do_reset();
    dreq(32'h100, 32'h100); dreq(32'h100, 32'hC0); dreq(32'h100, 32'h80);
    dreq(32'h100, 32'h40); expect_n("R5 underflow", 1, 32'h0, 0);
    do_reset();
    dreq(32'h100, 32'hFFFFFEC0); dreq(32'h100, 32'hFFFFFF00); dreq(32'h100, 32'hFFFFFF40);
    dreq(32'h100, 32'hFFFFFF80); expect_n("R5 overflow", 1, 32'hFFFFFFC0, 0);
  endtask

  task automatic t_ifetch();
    do_reset();
    req(32'h100, 32'h1234, 2'd0, 1'b1, 1'b0); expect_n("R6 next blocks", 2, 32'h1240, 32'h1280);
    dreq(32'h100, 32'h1000); dreq(32'h100, 32'h1040); dreq(32'h100, 32'h1080);
    dreq(32'h100, 32'h10C0); expect_n("R6 data trained", 2, 32'h1100, 32'h1140);
    req(32'h100, 32'h7777, 2'd0, 1'b1, 1'b0); expect_n("R6 ifetch a", 2, 32'h7780, 32'h77C0);
    req(32'h100, 32'h9999, 2'd0, 1'b1, 1'b0); expect_n("R6 ifetch b", 2, 32'h99C0, 32'h9A00);
    dreq(32'h100, 32'h1100); expect_n("R6 table untouched", 2, 32'h1140, 32'h1180);
    req(32'h100, 32'hFFFFFFC8, 2'd0, 1'b1, 1'b0); expect_n("R6 wrap none", 0, 0, 0);
    req(32'h100, 32'hFFFFFF90, 2'd0, 1'b1, 1'b0); expect_n("R6 wrap one", 1, 32'hFFFFFFC0, 0);
  endtask

  task automatic t_rid();
    do_reset();
    dreq(32'h108, 32'h4000); dreq(32'h108, 32'h4040); dreq(32'h108, 32'h4080);
    dreq(32'h108, 32'h40C0); expect_n("R7 rid0 trained", 2, 32'h4100, 32'h4140);
    req(32'h108, 32'h9000, 2'd1, 1'b0, 1'b0); req(32'h108, 32'h9100, 2'd1, 1'b0, 1'b0);
    expect_n("R7 rid1 miss", 0, 0, 0);
    dreq(32'h108, 32'h4100); expect_n("R7 rid0 intact", 2, 32'h4140, 32'h4180);
  endtask

  task automatic t_sec();
    do_reset();
    dreq(32'h10C, 32'h6000); dreq(32'h10C, 32'h6040); dreq(32'h10C, 32'h6080);
    dreq(32'h10C, 32'h60C0); expect_n("R8 nonsecure trained", 2, 32'h6100, 32'h6140);
    req(32'h10C, 32'hA000, 2'd0, 1'b0, 1'b1); req(32'h10C, 32'hA100, 2'd0, 1'b0, 1'b1);
    expect_n("R8 secure miss", 0, 0, 0);
    dreq(32'h10C, 32'h6100); expect_n("R8 nonsecure intact", 2, 32'h6140, 32'h6180);
  endtask

  task automatic t_inv();
    do_reset();
    dreq(32'h104, 32'h3000); dreq(32'h104, 32'h3040); dreq(32'h104, 32'h3080);
    dreq(32'h104, 32'h30C0); expect_n("R9 trained", 2, 32'h3100, 32'h3140);
    inv(2'd1, 1'b0);
    dreq(32'h104, 32'h3100); expect_n("R9 invalidated", 0, 0, 0);
    dreq(32'h104, 32'h3140); dreq(32'h104, 32'h3180);
    dreq(32'h104, 32'h31C0); expect_n("R9 retrained", 2, 32'h3200, 32'h3240);
    inv_valid_i = 1'b1; inv_set_i = 2'd1; inv_way_i = 1'b0;
    dreq(32'h104, 32'h3200); expect_n("R9 same-cycle hit", 2, 32'h3240, 32'h3280);
    dreq(32'h104, 32'h3240); expect_n("R9 clear wins", 0, 0, 0);
  endtask

  task automatic t_repl();
    do_reset();
    dreq(32'h100, 32'h1000); dreq(32'h100, 32'h1040); dreq(32'h100, 32'h1080);
    dreq(32'h100, 32'h10C0); expect_n("R10 A trained", 2, 32'h1100, 32'h1140);
    dreq(32'h110, 32'h2000); expect_n("R10 B alloc", 0, 0, 0);
    dreq(32'h100, 32'h1100); expect_n("R10 A touch", 2, 32'h1140, 32'h1180);
    dreq(32'h120, 32'h3000); expect_n("R10 C alloc", 0, 0, 0);
    dreq(32'h100, 32'h1140); expect_n("R10 A kept", 2, 32'h1180, 32'h11C0);
    dreq(32'h110, 32'h2040); expect_n("R10 B evicted", 0, 0, 0);
  endtask

  task automatic t_fifo();
    logic [31:0] head;
    do_reset();
    req(32'h0, 32'hFFFFFF90, 2'd0, 1'b1, 1'b0);
    req(32'h0, 32'h0000,     2'd0, 1'b1, 1'b0);
    req(32'h0, 32'h1000,     2'd0, 1'b1, 1'b0);
    req(32'h0, 32'h2000,     2'd0, 1'b1, 1'b0);
    req(32'h0, 32'h3000,     2'd0, 1'b1, 1'b0);
    req(32'h0, 32'h4000,     2'd0, 1'b1, 1'b0);
    head = pf_addr_o;
    repeat (2) @(negedge clk);
    check(pf_valid_o == 1'b1 && pf_addr_o == head, "R11 hold", pf_addr_o, head);
    exp_a[0] = 32'hFFFFFFC0; exp_a[1] = 32'h40;   exp_a[2] = 32'h80;   exp_a[3] = 32'h1040;
    exp_a[4] = 32'h1080;     exp_a[5] = 32'h2040; exp_a[6] = 32'h2080; exp_a[7] = 32'h3040;
    for (int i = 0; i < 8; i++) begin
      check(pf_valid_o == 1'b1 && pf_addr_o == exp_a[i], "R11 order", pf_addr_o, exp_a[i]);
      pf_ready_i = 1'b1;
      @(negedge clk);
    end
    pf_ready_i = 1'b0;
    check(pf_valid_o == 1'b0, "R11 overflow dropped", 32'(pf_valid_o), 32'h0);
  endtask

  initial begin
    t_reset_alloc();
    t_train();
    t_mispredict();
    t_suppress();
    t_ifetch();
    t_rid();
    t_sec();
    t_inv();
    t_repl();
    t_fifo();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule